// File: doc/BRIEF.md
# Aligned Load/Store Access Unit

This block sits between a processor pipeline and a 64-bit-wide store. It accepts one access at a time: a byte, 16-bit word, 32-bit longword or 64-bit quadword read or write, or a 32-bit instruction fetch. It checks that the virtual address is naturally aligned for the size. A misaligned access is dropped and reported on a one-cycle fault strobe.

An aligned access is either sent out for translation or used as its own physical address. Data accesses are translated when the mapping-enable input is set. Instruction fetches are translated unless the privileged-mode input is set, and they carry an instruction flag on the translate port. Physical addresses below `MEM_BYTES` reach an internal RAM organised as 64-bit words. Reads extract the addressed lane, right-justified and zero-extended. Narrow writes merge into the target lane and keep the other lanes. Addresses at or above `MEM_BYTES` go to an I/O request port that carries a size code.

Top module: `ldst_unit`

## Requirements
- R1: A word access with vaddr bit 0 set, a longword access or instruction fetch with vaddr bits 1:0 nonzero, or a quadword access with vaddr bits 2:0 nonzero produces `fault_valid` for one cycle, with `fault_vaddr` equal to the request address and `fault_cause` = 1, and no `rsp_valid`.
- R2: A byte access never faults, whatever its address.
- R3: A faulting access issues no translate request and no I/O request, and it leaves memory unchanged.
- R4: With `map_en` = 1, a data access raises `xlat_valid` with `xlat_vaddr` = request address and `xlat_acc` = 1 for a read or 2 for a write, and it holds the request until `xlat_ack`, then uses `xlat_paddr`. With `map_en` = 0, no translate request is made and the physical address equals the virtual address.
- R5: With `req_acc_ovr` = 1, `xlat_acc` carries `req_acc_code` instead of the read/write code.
- R6: An instruction fetch is a longword read. With `priv_mode` = 1 it is not translated. With `priv_mode` = 0 it is translated with `xlat_instr` = 1 and `xlat_acc` = 1. It returns 32 bits, zero-extended.
- R7: A memory read returns the bytes at physical addresses pa to pa+n-1 (n = 1, 2, 4 or 8 for size code 0, 1, 2 or 3), assembled little-endian, right-justified and zero-extended in `rsp_rdata`.
- R8: A byte, word or longword write replaces only the addressed n bytes with the low n bytes of `req_wdata`. A quadword write replaces all 8 bytes. A write response has `rsp_rdata` = 0.
- R9: A physical address at or above `MEM_BYTES` raises `io_valid` with `io_addr` = pa, `io_size` = the size code, `io_write`, and `io_wdata` masked to n bytes. A claimed read returns `io_rdata` masked to n bytes. An unclaimed read returns 0.
- R10: Only one access is outstanding. `req_ready` is low while a translation, memory step or I/O request is in progress, and it is low in the cycle before any `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | Data address mapping enabled |
| priv_mode | input | 1 | Privileged mode: instruction fetches untranslated |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | Instruction fetch (size and direction ignored) |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 quadword |
| req_vaddr | input | VA_W | Virtual address |
| req_wdata | input | 64 | Right-justified write data |
| req_acc_ovr | input | 1 | Use caller-supplied access code |
| req_acc_code | input | 4 | Caller-supplied access code |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 64 | Read data, right-justified, zero-extended |
| fault_valid | output | 1 | One-cycle alignment fault strobe |
| fault_vaddr | output | VA_W | Faulting virtual address |
| fault_cause | output | 2 | Fault cause code (1 = alignment) |
| xlat_valid | output | 1 | Translate request |
| xlat_instr | output | 1 | Request is for the instruction path |
| xlat_acc | output | 4 | Access code for the translation |
| xlat_vaddr | output | VA_W | Address to translate |
| xlat_ack | input | 1 | Translation done |
| xlat_paddr | input | PA_W | Translated physical address |
| io_valid | output | 1 | I/O request |
| io_write | output | 1 | I/O write |
| io_size | output | 2 | I/O size code |
| io_addr | output | PA_W | I/O physical address |
| io_wdata | output | 64 | I/O write data, masked to size |
| io_ack | input | 1 | I/O request done |
| io_claim | input | 1 | I/O read claimed by a device |
| io_rdata | input | 64 | I/O read data |

## Verification
The assertions assume that `xlat_ack` and `io_ack` are raised only while the matching request is high and for a single cycle. They also assume that `req_valid` is presented only when `req_ready` is high. The translation responder in the stimulus always returns an aligned physical address that keeps the low three address bits. The bench raises each acknowledge for exactly one cycle in reply to a request it observes, and it waits for a completion or fault before it issues the next access.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_Q = 2'd3} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_XLAT, ST_EXEC, ST_IO} state_e;

  localparam int          ACC_W       = 4;
  localparam logic [3:0]  ACC_RD      = 4'h1;
  localparam logic [3:0]  ACC_WR      = 4'h2;
  localparam logic [1:0]  CAUSE_ALIGN = 2'd1;

  // low address bits that must be zero for a size
  function automatic logic misaligned(size_e sz, logic [2:0] lo);
    case (sz)
      SZ_W:    return lo[0];
      SZ_L:    return |lo[1:0];
      SZ_Q:    return |lo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] size_mask(size_e sz);
    case (sz)
      SZ_B:    return 64'h0000_0000_0000_00FF;
      SZ_W:    return 64'h0000_0000_0000_FFFF;
      SZ_L:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // bit offset of the lane inside the 64-bit word
  function automatic logic [5:0] lane_shift(size_e sz, logic [2:0] lo);
    case (sz)
      SZ_B:    return {lo, 3'b000};
      SZ_W:    return {lo[2:1], 4'b0000};
      SZ_L:    return {lo[2], 5'b00000};
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [63:0] lane_extract(logic [63:0] w, size_e sz, logic [2:0] lo);
    return (w >> lane_shift(sz, lo)) & size_mask(sz);
  endfunction

  function automatic logic [63:0] lane_merge(logic [63:0] old, logic [63:0] d,
                                             size_e sz, logic [2:0] lo);
    logic [63:0] m;
    m = size_mask(sz) << lane_shift(sz, lo);
    return (old & ~m) | ((d & size_mask(sz)) << lane_shift(sz, lo));
  endfunction
endpackage

// File: rtl/ldst_align_chk.sv
module ldst_align_chk
  import ldst_pkg::*;
(
  input  logic       ifetch,
  input  logic [1:0] size_in,
  input  logic [2:0] addr_lo,
  output size_e      eff_size,
  output logic       align_fault
);
  // an instruction fetch is always a longword
  assign eff_size    = ifetch ? SZ_L : size_e'(size_in);
  assign align_fault = misaligned(eff_size, addr_lo);
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
(
  input  logic [63:0] word_in,
  input  logic [63:0] wdata,
  input  size_e       size,
  input  logic [2:0]  addr_lo,
  output logic [63:0] rd_lane,
  output logic [63:0] wr_word
);
  assign rd_lane = lane_extract(word_in, size, addr_lo);
  assign wr_word = lane_merge(word_in, wdata, size, addr_lo);
endmodule

// File: rtl/ldst_qword_ram.sv
module ldst_qword_ram #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [63:0]      wword,
  output logic [63:0]      rword
);
  logic [63:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wword;
  end

  assign rword = store[idx];
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int MEM_BYTES = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_en,
  input  logic            priv_mode,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_ifetch,
  input  logic [1:0]      req_size,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [63:0]     req_wdata,
  input  logic            req_acc_ovr,
  input  logic [3:0]      req_acc_code,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            fault_valid,
  output logic [VA_W-1:0] fault_vaddr,
  output logic [1:0]      fault_cause,
  output logic            xlat_valid,
  output logic            xlat_instr,
  output logic [3:0]      xlat_acc,
  output logic [VA_W-1:0] xlat_vaddr,
  input  logic            xlat_ack,
  input  logic [PA_W-1:0] xlat_paddr,
  output logic            io_valid,
  output logic            io_write,
  output logic [1:0]      io_size,
  output logic [PA_W-1:0] io_addr,
  output logic [63:0]     io_wdata,
  input  logic            io_ack,
  input  logic            io_claim,
  input  logic [63:0]     io_rdata
);
  localparam int              WORDS     = MEM_BYTES / 8;
  localparam int              IDX_W     = $clog2(WORDS);
  localparam logic [PA_W-1:0] MEM_LIMIT = PA_W'(MEM_BYTES);

  state_e          state;
  size_e           size_q;
  logic            write_q;
  logic            ifetch_q;
  logic [VA_W-1:0] vaddr_q;
  logic [63:0]     wdata_q;
  logic [3:0]      acc_q;
  logic [PA_W-1:0] pa_q;

  // named internal events
  size_e       eff_size;
  logic        align_fault;
  logic        need_xlat;
  logic [3:0]  acc_sel;
  logic        mem_hit;
  logic        mem_we;
  logic [63:0] ram_word;
  logic [63:0] rd_lane;
  logic [63:0] wr_word;

  ldst_align_chk u_align (
    .ifetch      (req_ifetch),
    .size_in     (req_size),
    .addr_lo     (req_vaddr[2:0]),
    .eff_size    (eff_size),
    .align_fault (align_fault)
  );

  assign need_xlat = req_ifetch ? ~priv_mode : map_en;
  assign acc_sel   = req_acc_ovr ? req_acc_code
                   : ((req_write && !req_ifetch) ? ACC_WR : ACC_RD);
  assign mem_hit   = pa_q < MEM_LIMIT;
  assign mem_we    = (state == ST_EXEC) && mem_hit && write_q;

  ldst_qword_ram #(.WORDS(WORDS)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .idx   (pa_q[IDX_W+2:3]),
    .wword (wr_word),
    .rword (ram_word)
  );

  ldst_lane_unit u_lane (
    .word_in (ram_word),
    .wdata   (wdata_q),
    .size    (size_q),
    .addr_lo (pa_q[2:0]),
    .rd_lane (rd_lane),
    .wr_word (wr_word)
  );

  assign req_ready  = (state == ST_IDLE);
  assign xlat_valid = (state == ST_XLAT);
  assign xlat_instr = ifetch_q;
  assign xlat_acc   = acc_q;
  assign xlat_vaddr = vaddr_q;
  assign io_valid   = (state == ST_IO);
  assign io_write   = write_q;
  assign io_size    = size_q;
  assign io_addr    = pa_q;
  assign io_wdata   = wdata_q & size_mask(size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      size_q      <= SZ_B;
      write_q     <= 1'b0;
      ifetch_q    <= 1'b0;
      vaddr_q     <= '0;
      wdata_q     <= '0;
      acc_q       <= '0;
      pa_q        <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      fault_valid <= 1'b0;
      fault_vaddr <= '0;
      fault_cause <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (align_fault) begin
              fault_valid <= 1'b1;
              fault_vaddr <= req_vaddr;
              fault_cause <= CAUSE_ALIGN;
            end else begin
              size_q   <= eff_size;
              write_q  <= req_write & ~req_ifetch;
              ifetch_q <= req_ifetch;
              vaddr_q  <= req_vaddr;
              wdata_q  <= req_wdata;
              acc_q    <= acc_sel;
              pa_q     <= PA_W'(req_vaddr);
              state    <= need_xlat ? ST_XLAT : ST_EXEC;
            end
          end
        end
        ST_XLAT: begin
          if (xlat_ack) begin
            pa_q  <= xlat_paddr;
            state <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (mem_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= write_q ? '0 : rd_lane;
            state     <= ST_IDLE;
          end else begin
            state <= ST_IO;
          end
        end
        ST_IO: begin
          if (io_ack) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= (!write_q && io_claim) ? (io_rdata & size_mask(size_q)) : '0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
  import ldst_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int MEM_BYTES = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            req_ifetch,
  input logic [1:0]      req_size,
  input logic            rsp_valid,
  input logic            fault_valid,
  input logic [1:0]      fault_cause,
  input logic            xlat_valid,
  input logic            xlat_ack,
  input logic [VA_W-1:0] xlat_vaddr,
  input logic            io_valid,
  input logic [PA_W-1:0] io_addr,
  input logic            mem_we
);
  localparam logic [PA_W-1:0] LIMIT = PA_W'(MEM_BYTES);

  // R1: a fault and a completion never share a cycle
  a_r1_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_valid && rsp_valid));

  // R1: the only cause reported is alignment
  a_r1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> fault_cause == CAUSE_ALIGN);

  // R2: bytes never fault
  a_r2_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> ($past(req_ifetch) || $past(req_size) != 2'd0));

  // R3: a fault coincides with no memory write
  a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !mem_we);

  // R4: translate request held with a steady address until acknowledged
  a_r4_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid && !xlat_ack) |=> (xlat_valid && $stable(xlat_vaddr)));

  // R9: I/O only sees addresses beyond memory
  a_r9_io_range: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid |-> io_addr >= LIMIT);

  // R10: busy while a request is outstanding
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid || io_valid) |-> !req_ready);

  // R10: a completion follows a busy cycle
  a_r10_rsp_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready));
endmodule

bind ldst_unit ldst_unit_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .MEM_BYTES(MEM_BYTES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .req_ifetch  (req_ifetch),
  .req_size    (req_size),
  .rsp_valid   (rsp_valid),
  .fault_valid (fault_valid),
  .fault_cause (fault_cause),
  .xlat_valid  (xlat_valid),
  .xlat_ack    (xlat_ack),
  .xlat_vaddr  (xlat_vaddr),
  .io_valid    (io_valid),
  .io_addr     (io_addr),
  .mem_we      (mem_we)
);

// File: tb/ldst_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_unit_tb_top;
  localparam int MEMB = 512;
  localparam logic [31:0] XOR_MAP = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic map_en = 0, priv_mode = 1;
  logic req_valid = 0, req_write = 0, req_ifetch = 0, req_acc_ovr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_vaddr = 0;
  logic [63:0] req_wdata = 0;
  logic [3:0] req_acc_code = 0;
  logic req_ready, rsp_valid, fault_valid, xlat_valid, xlat_instr, io_valid, io_write;
  logic [63:0] rsp_rdata, io_wdata;
  logic [31:0] fault_vaddr, xlat_vaddr, io_addr;
  logic [1:0] fault_cause, io_size;
  logic [3:0] xlat_acc;
  logic xlat_ack = 0, io_ack = 0, io_claim = 0;
  logic [31:0] xlat_paddr = 0;
  logic [63:0] io_rdata = 0;

  int checks = 0, errors = 0;
  bit in_access = 0;
  byte unsigned mdl [MEMB];

  always #2.5 clk = ~clk;

  ldst_unit dut_i (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model's idea of when outputs may fire
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !in_access) chk("R10", "stray completion", 1, 0);
    if (rst_n && rsp_valid && fault_valid) chk("R1", "fault with completion", 1, 0);
  end

  task automatic access(input bit w, input bit ifx, input int sz, input logic [31:0] va,
                        input logic [63:0] wd, input bit ovr = 0, input logic [3:0] code = 0);
    int eff, nb, xcnt, icnt;
    bit xl, got_rsp, got_flt, mis;
    logic [31:0] pa, xva, iad, fva;
    logic [3:0] xacc;
    logic xins, iwr;
    logic [1:0] isz, fcause;
    logic [63:0] rd, iwd, exp, msk;
    eff = ifx ? 2 : sz;
    nb = 1 << eff;
    msk = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 1);
    mis = (va & (nb - 1)) != 0;
    xcnt = 0; icnt = 0; got_rsp = 0; got_flt = 0;
    while (!req_ready) @(negedge clk);
    in_access = 1;
    req_valid = 1; req_write = w; req_ifetch = ifx; req_size = sz[1:0];
    req_vaddr = va; req_wdata = wd; req_acc_ovr = ovr; req_acc_code = code;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 200; c++) begin
      if (fault_valid) begin got_flt = 1; fva = fault_vaddr; fcause = fault_cause; break; end
      if (rsp_valid) begin got_rsp = 1; rd = rsp_rdata; break; end
      if (xlat_valid && !xlat_ack) begin
        xlat_ack = 1; xlat_paddr = xlat_vaddr ^ XOR_MAP;
        xcnt++; xacc = xlat_acc; xins = xlat_instr; xva = xlat_vaddr;
      end else xlat_ack = 0;
      if (io_valid && !io_ack) begin
        io_ack = 1; io_claim = ~io_addr[4]; io_rdata = {32'hCAFE_F00D, io_addr};
        icnt++; iad = io_addr; isz = io_size; iwr = io_write; iwd = io_wdata;
      end else io_ack = 0;
      @(negedge clk);
    end
    xlat_ack = 0; io_ack = 0;
    @(negedge clk);
    in_access = 0;
    if (!got_rsp && !got_flt) begin chk("R10", "access timed out", 0, 1); return; end
    if (mis) begin
      chk("R1", "fault raised", got_flt, 1);
      chk("R1", "fault vaddr", fva, va);
      chk("R1", "fault cause", fcause, 1);
      chk("R3", "no translate/io on fault", xcnt + icnt, 0);
      return;
    end
    chk(eff == 0 ? "R2" : "R1", "no fault on aligned", got_flt, 0);
    xl = ifx ? !priv_mode : map_en;
    chk(ifx ? "R6" : "R4", "translate count", xcnt, xl);
    if (xl && xcnt == 1) begin
      chk("R4", "translate vaddr", xva, va);
      chk(ovr ? "R5" : (ifx ? "R6" : "R4"), "access code", xacc,
          ovr ? code : ((w && !ifx) ? 4'h2 : 4'h1));
      chk("R6", "instr flag", xins, ifx);
    end
    pa = xl ? (va ^ XOR_MAP) : va;
    if (pa < MEMB) begin
      chk("R9", "no io for memory", icnt, 0);
      if (w && !ifx) begin
        for (int i = 0; i < nb; i++) mdl[pa + i] = wd[8*i +: 8];
        chk("R8", "write rdata zero", rd, 0);
      end else begin
        exp = 0;
        for (int i = 0; i < nb; i++) exp |= 64'(mdl[pa + i]) << (8 * i);
        chk(ifx ? "R6" : "R7", "read data", rd, exp);
      end
    end else begin
      chk("R9", "io count", icnt, 1);
      chk("R9", "io addr", iad, pa);
      chk("R9", "io size", isz, eff[1:0]);
      chk("R9", "io write", iwr, w && !ifx);
      if (w && !ifx) chk("R9", "io wdata", iwd, wd & msk);
      else chk("R9", "io rdata", rd, pa[4] ? 64'd0 : ({32'hCAFE_F00D, pa} & msk));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk("R10", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset ready", req_ready, 1);
    chk("R1", "reset fault", fault_valid, 0);
    chk("R10", "reset rsp", rsp_valid, 0);
    chk("R4", "reset xlat", xlat_valid, 0);
    chk("R9", "reset io", io_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // fill memory with quadwords
    for (int i = 0; i < MEMB / 8; i++)
      access(1, 0, 3, 32'(i * 8), 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101));
    // R7 lane extraction
    for (int o = 0; o < 8; o++) access(0, 0, 0, 32'h28 + 32'(o), 0);
    for (int o = 0; o < 8; o += 2) access(0, 0, 1, 32'h30 + 32'(o), 0);
    access(0, 0, 2, 32'h38, 0);
    access(0, 0, 2, 32'h3C, 0);
    access(0, 0, 3, 32'h40, 0);
    // R8 partial merges then read back whole words
    access(1, 0, 0, 32'h2B, 64'hFFFF_FFFF_FFFF_FF5A);
    access(1, 0, 1, 32'h32, 64'h1111_2222_3333_BEEF);
    access(1, 0, 2, 32'h44, 64'hAAAA_AAAA_DEAD_C0DE);
    access(1, 0, 2, 32'h48, 64'h5555_5555_0BAD_F00D);
    access(0, 0, 3, 32'h28, 0);
    access(0, 0, 3, 32'h30, 0);
    access(0, 0, 3, 32'h40, 0);
    access(0, 0, 3, 32'h48, 0);
    // R1/R3 misalignment then read back; R2 odd bytes
    access(0, 0, 1, 32'h11, 0);
    access(1, 0, 2, 32'h22, 64'hFFFF_FFFF);
    access(1, 0, 2, 32'h21, 64'hFFFF_FFFF);
    access(1, 0, 3, 32'h0C, '1);
    access(1, 0, 3, 32'h09, '1);
    access(0, 0, 3, 32'h08, 0);
    access(0, 0, 3, 32'h20, 0);
    access(1, 0, 0, 32'h17, 64'h77);
    access(0, 0, 0, 32'h17, 0);
    // R4/R5 mapping
    map_en = 1;
    access(0, 0, 3, 32'h40, 0);
    access(1, 0, 1, 32'h56, 64'h0000_0000_0000_A5C3);
    access(0, 0, 3, 32'h50, 0);
    access(0, 0, 2, 32'h64, 0, 1, 4'h7);
    access(1, 0, 0, 32'h65, 64'h3C, 1, 4'hB);
    access(0, 0, 1, 32'h63, 0);
    // R6 instruction fetch
    access(0, 1, 3, 32'h4C, 0);
    access(1, 1, 0, 32'h4A, 64'hFF);
    priv_mode = 0;
    access(0, 1, 0, 32'h44, 0);
    access(0, 1, 1, 32'h5E, 0);
    priv_mode = 1;
    // R9 I/O
    map_en = 0;
    access(0, 0, 0, 32'h1003, 0);
    access(0, 0, 1, 32'h1012, 0);
    access(1, 0, 2, 32'h2004, 64'h9999_8888_7777_6666);
    access(0, 0, 3, 32'h3008, 0);
    access(0, 0, 2, 32'h200, 0);
    access(1, 0, 0, 32'h1FF, 64'h1234);
    access(0, 0, 0, 32'h1FF, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule